// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous SRAM for a shared data bus. A command is sampled on one rising clock edge. The data for that command moves exactly two rising edges later, whether it is a read or a write. Because every command has the same latency, reads and writes can alternate on every cycle and the bus never needs an idle cycle.

A command carries an address, a read/write select and per-lane write enables. It is loaded when the advance/load strobe is low and all three chip enables are true. With the strobe high, an on-chip 4-beat burst counter moves to the next address of the burst. It follows a linear or an interleaved order, chosen by a static input.

Three inputs suspend the block:
- A high clock enable makes an edge have no effect.
- A high sleep input gates the internal clock and keeps the contents.
- A high output enable forces the data outputs to high impedance at once.

The bidirectional bus is split into separate data-in, data-out and output-enable ports.

Writes are committed to the array one edge after their data edge. A read that meets a pending write to the same word takes the written lanes from that write.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded on edge E, followed by two edges that are not stalled, drives data_oe_o high after the second of those edges. When reset is released, data_oe_o is low.
- R2: A write loaded on edge E takes data_i as sampled on edge E+2 and stores it at its address. A later read of that address returns the value.
- R3: Lane i covers data bits [9i+8:9i]. Only lanes whose lane_we_ni bit is 0 are written. lane_we_ni is ignored on reads, so a read does not change the stored data.
- R4: On an edge with cken_ni high, all synchronous inputs are ignored. data_o, data_oe_o and every pipeline stage hold. Work already in the pipeline resumes in its exact place afterwards.
- R5: A load needs adv_ld_i=0, cs0_ni=0, cs1_i=1 and cs2_ni=0. Any other enable value with adv_ld_i=0 is a deselect. Commands already issued still complete, and the bus is not driven after the second edge following the deselect. A deselected write changes nothing.
- R6: data_oe_o is low after the second edge following a loaded write.
- R7: oe_ni high forces data_oe_o low without waiting for a clock edge.
- R8: An edge with sleep_i high acts like a stalled edge. Pipeline, outputs and array contents are kept.
- R9: With seq_linear_i=1, a burst from base B reads the addresses whose two low bits are (B+k) mod 4 for k=0..3, with the upper bits fixed.
- R10: With seq_linear_i=0, the two low bits of beat k are B xor k.
- R11: A read loaded the edge after a write to the same address returns the write's enabled lanes merged over the old word.
- R12: A read, a write and a read issued on consecutive edges each transfer on their own data edge, with no idle cycle in between.
- R13: adv_ld_i high when no burst is active (after a deselect) starts no operation, and the bus stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cken_ni | input | 1 | Clock enable, active low |
| sleep_i | input | 1 | Sleep, gates internal clock |
| adv_ld_i | input | 1 | 0 = load command, 1 = advance burst |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| cs0_ni | input | 1 | Chip enable, active low |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_ni | input | 1 | Chip enable, active low |
| lane_we_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| seq_linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_i | input | LANES*LANE_W | Write data bus |
| data_o | output | LANES*LANE_W | Read data bus |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
The latency assertions assume that no stall or sleep edge falls inside the two-edge window they observe. They only fire when both edges that follow a command actually step, so stalled runs are not checked by them and are covered by the hold properties instead. The bench holds seq_linear_i constant during any burst. It drives write data only on the data edge of the write it belongs to, and it reads only addresses it has written earlier, so every expected word is defined.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] base,
                                                    input logic [BEAT_W-1:0] beat,
                                                    input logic              linear);
    return linear ? BEAT_W'(base + beat) : (base ^ beat);
  endfunction
endpackage

// File: rtl/zbt_sram_burst.sv
module zbt_sram_burst
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;

  assign beat_nxt = beat_q + BEAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (step_i) begin
      if (load_i) begin
        base_q <= base_i;
        beat_q <= '0;
      end else if (adv_i) begin
        beat_q <= beat_nxt;
      end
    end
  end

  // next beat address, upper bits fixed, wraps inside the 4-word block
  assign addr_o = {base_q[ADDR_W-1:BEAT_W], beat_offset(base_q[BEAT_W-1:0], beat_nxt, linear_i)};
endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wmask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbt_sram_fwd.sv
module zbt_sram_fwd #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    hit_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] arr_i,
  input  logic [LANES*LANE_W-1:0] pend_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[g*LANE_W +: LANE_W] = (hit_i && mask_i[g]) ? pend_i[g*LANE_W +: LANE_W]
                                                            : arr_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cken_ni,
  input  logic                    sleep_i,
  input  logic                    adv_ld_i,
  input  logic                    rd_wr_i,
  input  logic                    cs0_ni,
  input  logic                    cs1_i,
  input  logic                    cs2_ni,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    seq_linear_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic step, sel, load, advance;
  logic burst_q, rd_q;
  logic [ADDR_W-1:0] burst_addr;

  logic              s0_vld, s0_rd;
  logic [ADDR_W-1:0] s0_addr;
  logic [LANES-1:0]  s0_mask;

  logic              p1_vld_q, p1_rd_q, p2_vld_q, p2_rd_q;
  logic [ADDR_W-1:0] p1_addr_q, p2_addr_q;
  logic [LANES-1:0]  p1_mask_q, p2_mask_q;

  logic              wb_vld_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [LANES-1:0]  wb_mask_q;
  logic [DATA_W-1:0] wb_data_q;

  logic [DATA_W-1:0] arr_rdata, fwd_data, out_q;
  logic              out_vld_q, fwd_hit;

  // sleep gates the clock the same way a stall does
  assign step    = ~cken_ni & ~sleep_i;
  assign sel     = ~cs0_ni & cs1_i & ~cs2_ni;
  assign load    = ~adv_ld_i & sel;
  assign advance = adv_ld_i & burst_q;

  assign s0_vld  = load | advance;
  assign s0_rd   = load ? rd_wr_i : rd_q;
  assign s0_addr = load ? addr_i : burst_addr;
  assign s0_mask = ~lane_we_ni;

  zbt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .load_i  (load),
    .adv_i   (advance),
    .linear_i(seq_linear_i),
    .base_i  (addr_i),
    .addr_o  (burst_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q   <= 1'b0;
      rd_q      <= 1'b0;
      p1_vld_q  <= 1'b0;
      p1_rd_q   <= 1'b0;
      p1_addr_q <= '0;
      p1_mask_q <= '0;
      p2_vld_q  <= 1'b0;
      p2_rd_q   <= 1'b0;
      p2_addr_q <= '0;
      p2_mask_q <= '0;
    end else if (step) begin
      if (!adv_ld_i) burst_q <= sel;  // deselect ends any burst
      if (load) rd_q <= rd_wr_i;
      p1_vld_q  <= s0_vld;
      p1_rd_q   <= s0_rd;
      p1_addr_q <= s0_addr;
      p1_mask_q <= s0_mask;
      p2_vld_q  <= p1_vld_q;
      p2_rd_q   <= p1_rd_q;
      p2_addr_q <= p1_addr_q;
      p2_mask_q <= p1_mask_q;
    end
  end

  // data stage: write data captured into a pending buffer, read data registered out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_vld_q  <= 1'b0;
      wb_addr_q <= '0;
      wb_mask_q <= '0;
      wb_data_q <= '0;
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (step) begin
      wb_vld_q  <= p2_vld_q & ~p2_rd_q;
      out_vld_q <= p2_vld_q & p2_rd_q;
      if (p2_vld_q && !p2_rd_q) begin
        wb_addr_q <= p2_addr_q;
        wb_mask_q <= p2_mask_q;
        wb_data_q <= data_i;
      end
      if (p2_vld_q && p2_rd_q) out_q <= fwd_data;
    end
  end

  zbt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (step & wb_vld_q),
    .waddr_i(wb_addr_q),
    .wmask_i(wb_mask_q),
    .wdata_i(wb_data_q),
    .raddr_i(p2_addr_q),
    .rdata_o(arr_rdata)
  );

  assign fwd_hit = wb_vld_q & (wb_addr_q == p2_addr_q);

  zbt_sram_fwd #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
    .hit_i (fwd_hit),
    .mask_i(wb_mask_q),
    .arr_i (arr_rdata),
    .pend_i(wb_data_q),
    .data_o(fwd_data)
  );

  assign data_o    = out_q;
  assign data_oe_o = out_vld_q & ~oe_ni;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cken_ni,
  input logic              sleep_i,
  input logic              adv_ld_i,
  input logic              rd_wr_i,
  input logic              cs0_ni,
  input logic              cs1_i,
  input logic              cs2_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic step, sel, go_rd, go_wr, go_desel;
  assign step     = !cken_ni && !sleep_i;
  assign sel      = !cs0_ni && cs1_i && !cs2_ni;
  assign go_rd    = step && !adv_ld_i && sel && rd_wr_i;
  assign go_wr    = step && !adv_ld_i && sel && !rd_wr_i;
  assign go_desel = step && !adv_ld_i && !sel;

  a_r1_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_rd ##1 step ##1 step) |=> (data_oe_o || oe_ni));

  a_r6_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr ##1 step ##1 step) |=> !data_oe_o);

  a_r5_desel_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_desel ##1 step ##1 step) |=> !data_oe_o);

  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cken_ni |=> $stable(data_o));

  a_r8_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(data_o));

  a_r7_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !oe_ni);
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cken_ni  (cken_ni),
  .sleep_i  (sleep_i),
  .adv_ld_i (adv_ld_i),
  .rd_wr_i  (rd_wr_i),
  .cs0_ni   (cs0_ni),
  .cs1_i    (cs1_i),
  .cs2_ni   (cs2_ni),
  .oe_ni    (oe_ni),
  .data_o   (data_o),
  .data_oe_o(data_oe_o)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cken_ni = 1'b0, sleep_i = 1'b0, adv_ld_i = 1'b0, rd_wr_i = 1'b1;
  logic        cs0_ni = 1'b1, cs1_i = 1'b1, cs2_ni = 1'b0;
  logic [3:0]  lane_we_ni = 4'hF;
  logic [5:0]  addr_i = '0;
  logic        seq_linear_i = 1'b1;
  logic        oe_ni = 1'b0;
  logic [35:0] data_i = '0;
  logic [35:0] data_o;
  logic        data_oe_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  zbt_sram uut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [35:0] pat(input int a);
    return (36'(a) * 36'h011111111) ^ 36'h90A0B0C0D;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [35:0] exp);
    chk({tag, " oe"}, 36'(data_oe_o), 36'd1);
    chk({tag, " data"}, data_o, exp);
  endtask

  task automatic chk_hiz(input string tag);
    chk({tag, " hiz"}, 36'(data_oe_o), 36'd0);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic ld(input logic rd, input int a, input logic [3:0] bw, input logic [35:0] din);
    adv_ld_i = 1'b0; cs0_ni = 1'b0; cs1_i = 1'b1; cs2_ni = 1'b0;
    rd_wr_i = rd; addr_i = a[5:0]; lane_we_ni = bw; data_i = din;
    tick();
  endtask

  task automatic nop(input logic [35:0] din);
    adv_ld_i = 1'b0; cs0_ni = 1'b1; cs1_i = 1'b1; cs2_ni = 1'b0;
    data_i = din; lane_we_ni = 4'hF;
    tick();
  endtask

  task automatic adv(input logic [35:0] din);
    adv_ld_i = 1'b1; data_i = din; lane_we_ni = 4'hF;
    tick();
  endtask

  task automatic wr_full(input int a, input logic [3:0] bw, input logic [35:0] d);
    ld(1'b0, a, bw, '0);
    nop('0);
    nop(d);
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [35:0] exp);
    ld(1'b1, a, 4'h0, '0);
    nop('0);
    nop('0);
    chk_rd(tag, exp);
    nop('0);
  endtask

  // R2 R6 R12: back-to-back writes and reads
  task automatic t_alternate();
    ld(1'b0, 3, 4'h0, '0);
    ld(1'b0, 10, 4'h0, '0);
    ld(1'b1, 3, 4'h0, pat(3));
    chk_hiz("R6 write data edge");
    ld(1'b0, 11, 4'h0, pat(10));
    chk_hiz("R6 second write data edge");
    ld(1'b1, 10, 4'h0, '0);
    chk_rd("R2 read back a3", pat(3));
    nop(pat(11));
    chk_hiz("R12 write between reads");
    nop('0);
    chk_rd("R12 read a10 no dead cycle", pat(10));
    nop('0);
    rd_chk("R2 read back a11", 11, pat(11));
  endtask

  // R11: read right after a partial write to the same word
  task automatic t_forward();
    logic [35:0] old_d, new_d, exp;
    old_d = 36'h1_2345_6789;
    new_d = 36'hE_DCBA_9876;
    wr_full(20, 4'h0, old_d);
    nop('0);
    ld(1'b0, 20, 4'b1010, '0);
    ld(1'b1, 20, 4'h0, '0);
    nop(new_d);
    nop('0);
    exp = {old_d[35:27], new_d[26:18], old_d[17:9], new_d[8:0]};
    chk_rd("R11 forwarded merge", exp);
    nop('0);
    rd_chk("R11 merge committed", 20, exp);
  endtask

  // R3: lane masks, and lanes ignored on reads
  task automatic t_lanes();
    logic [35:0] da, db, exp;
    da = 36'h5_5555_5555;
    db = 36'hA_AAAA_AAAA;
    wr_full(30, 4'h0, da);
    wr_full(30, 4'b0110, db);
    nop('0);
    exp = {db[35:27], da[26:9], db[8:0]};
    ld(1'b1, 30, 4'b0000, '0);
    nop('0);
    nop('0);
    chk_rd("R3 lane merge", exp);
    nop('0);
    rd_chk("R3 read lanes ignored", 30, exp);
  endtask

  // R4 / R8: stall or sleep freezes everything
  task automatic t_freeze(input bit use_sleep);
    string tag;
    tag = use_sleep ? "R8" : "R4";
    ld(1'b1, 3, 4'h0, '0);
    ld(1'b1, 10, 4'h0, '0);
    nop('0);
    chk_rd({tag, " before freeze"}, pat(3));
    adv_ld_i = 1'b0; cs0_ni = 1'b0; cs1_i = 1'b1; cs2_ni = 1'b0;
    rd_wr_i = 1'b0; addr_i = 6'd3; lane_we_ni = 4'h0; data_i = 36'hF_FFFF_FFFF;
    if (use_sleep) sleep_i = 1'b1; else cken_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_rd({tag, " held"}, pat(3));
    end
    sleep_i = 1'b0; cken_ni = 1'b0;
    nop('0);
    chk_rd({tag, " resumed in place"}, pat(10));
    nop('0);
    chk_hiz({tag, " drained"});
    rd_chk({tag, " frozen write ignored"}, 3, pat(3));
  endtask

  // R5 R13: each chip enable deselects; pending read completes
  task automatic t_deselect();
    for (int v = 0; v < 3; v++) begin
      ld(1'b1, 3, 4'h0, '0);
      adv_ld_i = 1'b0; rd_wr_i = 1'b0; addr_i = 6'd3; lane_we_ni = 4'h0;
      cs0_ni = (v == 0); cs1_i = (v != 1); cs2_ni = (v == 2);
      tick();
      adv('0);
      chk_rd("R5 pending read completes", pat(3));
      adv(36'h0_0000_0001);
      chk_hiz("R5 two edges after deselect");
      adv(36'h0_0000_0002);
      chk_hiz("R13 advance without burst");
      nop('0);
      nop('0);
      rd_chk("R5 deselected write ignored", 3, pat(3));
    end
  endtask

  // R7: asynchronous output enable
  task automatic t_oe();
    ld(1'b1, 10, 4'h0, '0);
    nop('0);
    nop('0);
    chk_rd("R1 read drives", pat(10));
    oe_ni = 1'b1;
    #0.5;
    chk_hiz("R7 oe high");
    oe_ni = 1'b0;
    #0.5;
    chk("R7 oe released", 36'(data_oe_o), 36'd1);
    nop('0);
  endtask

  // R9 R10: burst orders
  task automatic t_burst(input bit lin, input int base, input int e0, input int e1,
                         input int e2, input int e3);
    string tag;
    tag = lin ? "R9" : "R10";
    seq_linear_i = lin;
    ld(1'b1, base, 4'h0, '0);
    adv('0);
    adv('0);
    chk_rd({tag, " beat0"}, pat(e0));
    adv('0);
    chk_rd({tag, " beat1"}, pat(e1));
    nop('0);
    chk_rd({tag, " beat2"}, pat(e2));
    nop('0);
    chk_rd({tag, " beat3"}, pat(e3));
    nop('0);
    chk_hiz({tag, " burst done"});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_hiz("R1 reset state");
    nop('0);
    t_alternate();
    t_forward();
    t_lanes();
    t_freeze(1'b0);
    t_freeze(1'b1);
    t_deselect();
    t_oe();
    for (int a = 40; a < 44; a++) wr_full(a, 4'h0, pat(a));
    nop('0);
    t_burst(1'b1, 42, 42, 43, 40, 41);
    t_burst(1'b0, 41, 41, 40, 43, 42);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule